// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block is the digital controller that sits in front of a six-bit step attenuator. It takes its control word either from a three-wire serial port or from six parallel pins, and it drives six active-low switch controls. Each control bit that is low switches in one binary-weighted attenuation section. A mode pin picks the interface. A latch pin decides when a new word takes effect. In parallel mode, the latch pin held high makes the pins transparent, and a high pulse on it captures the pins.

Every pin is treated as asynchronous. Each pin passes through a two-flop synchronizer clocked by a fast system clock, and the block finds the edges of the serial clock and of the latch pin itself. The serial port has a pass-through output, which carries the bit leaving the six-stage shift register. This lets several attenuators share one serial bus in a daisy chain.

After reset, a power-up timer holds the outputs at maximum attenuation. When the timer expires, a default state is loaded. That state comes from two strap pins, or from the parallel pins when the latch pin is high at that moment.

Top module: `step_atten_ctrl`

## Requirements
- R1: The mode input selects the word source: 1 means serial, 0 means parallel. In serial mode the parallel pins have no effect, and in parallel mode the serial shift register never reaches the control outputs.
- R2: In serial mode, bits enter the shift register on each rising serial clock, first-sent bit ending in the MSB (ctl_n_o[5]). A rising edge on the latch pin copies the register to ctl_n_o. Shifting without such an edge leaves ctl_n_o unchanged.
- R3: While the latch pin is high, rising serial clock edges do not change the shift register.
- R4: sdo_o is the MSB of the shift register. It therefore presents the serial input delayed by six serial clock edges, and it changes only after a detected rising serial clock.
- R5: In parallel mode with the latch pin high, ctl_n_o follows par_i.
- R6: In parallel mode with the latch pin low, ctl_n_o holds the value that par_i had while the latch pin was last high.
- R7: ctl_n_o is active-low. Attenuation in 0.5 dB units equals 63 minus the unsigned value of ctl_n_o, so a low bit k adds 2^k half-dB steps: all ones is 0 dB and all zeros is 31.5 dB.
- R8: When the power-up timer expires with the latch pin low, the strap pins select the state. {strap_b_i, strap_a_i} = 00 gives 31.5 dB, 01 gives 24 dB, 10 gives 16 dB and 11 gives 0 dB.
- R9: When the power-up timer expires with the latch pin high, ctl_n_o takes par_i, in either mode.
- R10: From reset until the power-up timer of PWRUP_CYCLES system clocks expires, ctl_n_o is all zeros (maximum attenuation).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_ser_i | input | 1 | Interface select: 1 serial, 0 parallel |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data input |
| latch_i | input | 1 | Latch / transfer control |
| par_i | input | 6 | Parallel control word, bit 0 is the 0.5 dB section |
| strap_a_i | input | 1 | Power-up strap, low bit of the default selector |
| strap_b_i | input | 1 | Power-up strap, high bit of the default selector |
| ctl_n_o | output | 6 | Active-low switch controls to the attenuator sections |
| sdo_o | output | 1 | Serial pass-through output for cascading |

## Verification
Any pin change reaches the outputs on the third rising system clock after it. Two edges go to the synchronizer, and the update comes on the edge after the edge detector sees the new level. The bench therefore holds each serial clock and latch level for at least four system cycles, and it samples outputs on a falling edge six cycles after its last input change. The power-up result is due PWRUP_CYCLES plus two cycles after reset release, because of the reset synchronizer. It is checked once well inside that window and once well after it. The pass-through output is compared before every serial clock pulse with the bit the previous word left at that position.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int ATT_W     = 6;
  localparam int FULL_HALF = (1 << ATT_W) - 1;

  // convert an attenuation in half-dB units to the active-low control code
  function automatic logic [ATT_W-1:0] half_db_to_code(input int unsigned half_db);
    half_db_to_code = ATT_W'(FULL_HALF - half_db);
  endfunction

  // default state chosen by the two strap pins
  function automatic logic [ATT_W-1:0] strap_code(input logic sa, input logic sb);
    logic [ATT_W-1:0] code;
    unique case ({sb, sa})
      2'b00:   code = half_db_to_code(63);
      2'b01:   code = half_db_to_code(48);
      2'b10:   code = half_db_to_code(32);
      default: code = half_db_to_code(0);
    endcase
    return code;
  endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/atten_edge.sv
module atten_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/atten_pwrup.sv
module atten_pwrup #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          expire;

  assign expire = !done_q && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (expire)       done_d = 1'b1;
    else if (!done_q) cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign expire_o = expire;
  assign done_o   = done_q;
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int PWRUP_CYCLES = 1000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_ser_i,
  input  logic                       sclk_i,
  input  logic                       sdata_i,
  input  logic                       latch_i,
  input  logic [atten_pkg::ATT_W-1:0] par_i,
  input  logic                       strap_a_i,
  input  logic                       strap_b_i,
  output logic [atten_pkg::ATT_W-1:0] ctl_n_o,
  output logic                       sdo_o
);
  import atten_pkg::*;

  localparam int NSYNC = ATT_W + 6;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // synchronize every pin
  logic [NSYNC-1:0] raw_in, syn_in;
  logic             sclk_s, sdata_s, latch_s, mode_s, sa_s, sb_s;
  logic [ATT_W-1:0] par_s;

  assign raw_in = {par_i, strap_b_i, strap_a_i, mode_ser_i, latch_i, sdata_i, sclk_i};

  atten_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign {par_s, sb_s, sa_s, mode_s, latch_s, sdata_s, sclk_s} = syn_in;

  // edge detection
  logic sclk_rise, latch_rise;
  atten_edge u_sclk_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl_i(sclk_s), .rise_o(sclk_rise)
  );
  atten_edge u_latch_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl_i(latch_s), .rise_o(latch_rise)
  );

  // serial shift register, clock masked while latch is high
  logic             shift_en;
  logic [ATT_W-1:0] sr_q;
  assign shift_en = sclk_rise & ~latch_s;

  atten_shift #(.W(ATT_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(shift_en), .din(sdata_s), .sr_o(sr_q)
  );

  // power-up timer
  logic pw_expire, pw_done;
  atten_pwrup #(.CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk(clk), .rst_n(rst_sync_n), .expire_o(pw_expire), .done_o(pw_done)
  );

  // control word register
  logic [ATT_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (!pw_done) begin
      if (pw_expire) word_d = latch_s ? par_s : strap_code(sa_s, sb_s);
    end else if (mode_s) begin
      if (latch_rise) word_d = sr_q;
    end else if (latch_s) begin
      word_d = par_s;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) word_q <= '0;
    else             word_q <= word_d;
  end

  assign ctl_n_o = word_q;
  assign sdo_o   = sr_q[ATT_W-1];
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pw_done,
  input logic         latch_s,
  input logic         latch_rise,
  input logic         mode_s,
  input logic         sclk_rise,
  input logic [W-1:0] sr_q,
  input logic [W-1:0] par_s,
  input logic [W-1:0] ctl_n_o,
  input logic         sdo_o
);
  // R10
  pwrup_max_atten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_done |-> ctl_n_o == '0);

  // R3
  shift_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_s |=> $stable(sr_q));

  // R4
  sdo_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !latch_s) |=> sdo_o == $past(sr_q[W-2]));

  // R2
  serial_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && mode_s && latch_rise) |=> ctl_n_o == $past(sr_q));

  // R5
  par_transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && !mode_s && latch_s) |=> ctl_n_o == $past(par_s));

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_done && !latch_s) |=> $stable(ctl_n_o));
endmodule

bind step_atten_ctrl atten_ctrl_chk #(.W(atten_pkg::ATT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pw_done(pw_done), .latch_s(latch_s),
  .latch_rise(latch_rise), .mode_s(mode_s), .sclk_rise(sclk_rise),
  .sr_q(sr_q), .par_s(par_s), .ctl_n_o(ctl_n_o), .sdo_o(sdo_o)
);

// File: tb/tb_step_atten_ctrl.sv
module tb_step_atten_ctrl;
  localparam int PW = 24;

  logic       clk = 1'b0;
  logic       rst_n, mode, sclk, sdata, latch, sa, sb;
  logic [5:0] par;
  logic [5:0] ctl;
  logic       sdo;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  step_atten_ctrl #(.SYNC_STAGES(2), .PWRUP_CYCLES(PW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_ser_i(mode), .sclk_i(sclk), .sdata_i(sdata),
    .latch_i(latch), .par_i(par), .strap_a_i(sa), .strap_b_i(sb),
    .ctl_n_o(ctl), .sdo_o(sdo)
  );

  function automatic logic [5:0] code_of(input int half_db);
    return 6'(63 - half_db);
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1; wait_n(4);
    sclk = 1'b0; wait_n(4);
  endtask

  task automatic pulse_latch();
    latch = 1'b1; wait_n(6);
    latch = 1'b0; wait_n(6);
  endtask

  task automatic do_reset(input logic a, input logic b, input logic le,
                          input logic [5:0] p, input logic [5:0] exp, input string req);
    @(negedge clk);
    rst_n = 1'b0; sa = a; sb = b; latch = le; par = p; mode = 1'b1;
    sclk = 1'b0; sdata = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(PW / 2);
    chk("R10 max attenuation during power-up delay", ctl, 6'b000000);
    wait_n(PW + 4);
    chk(req, ctl, exp);
  endtask

  // shift a word MSB first; check sdo against the previous register content
  task automatic shift_word(input logic [5:0] w, input logic [5:0] prev);
    for (int i = 5; i >= 0; i--) begin
      sdata = w[i];
      wait_n(2);
      chk("R4 sdo delayed by six", {5'b0, sdo}, {5'b0, prev[i]});
      pulse_sclk();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [5:0] prev;
    rst_n = 1'b0; mode = 1'b1; sclk = 1'b0; sdata = 1'b0; latch = 1'b0;
    par = '0; sa = 1'b0; sb = 1'b0;

    // R8: strap defaults with latch low; R7 expected codes from dB values
    do_reset(1'b0, 1'b0, 1'b0, 6'h2A, code_of(63), "R8 straps 00 -> 31.5 dB");
    do_reset(1'b1, 1'b0, 1'b0, 6'h2A, code_of(48), "R8 straps 01 -> 24 dB");
    do_reset(1'b0, 1'b1, 1'b0, 6'h2A, code_of(32), "R8 straps 10 -> 16 dB");
    do_reset(1'b1, 1'b1, 1'b0, 6'h2A, code_of(0),  "R8 straps 11 -> 0 dB");
    // R9: latch high at expiry takes parallel pins (serial mode, so no transparency after)
    do_reset(1'b0, 1'b0, 1'b1, 6'h15, 6'h15, "R9 latch high at power-up");
    latch = 1'b0;
    wait_n(6);

    // R2/R4: sweep all serial words
    prev = 6'h00;
    for (int w = 0; w < 64; w++) begin
      shift_word(6'(w), prev);
      latch = 1'b1; wait_n(6);
      chk("R2 serial word transferred on latch rise", ctl, 6'(w));
      latch = 1'b0; wait_n(6);
      prev = 6'(w);
    end

    // R2: shifting without latch edge does not change outputs
    shift_word(6'b010011, prev);
    chk("R2 no transfer without latch edge", ctl, 6'd63);
    pulse_latch();
    chk("R2 serial word 010011", ctl, 6'b010011);

    // R3: serial clock masked while latch is high
    latch = 1'b1; wait_n(6);
    for (int k = 0; k < 3; k++) begin
      sdata = ~sdata;
      wait_n(2);
      pulse_sclk();
    end
    latch = 1'b0; wait_n(6);
    chk("R3 masked shift leaves sdo", {5'b0, sdo}, 6'b000000);
    pulse_latch();
    chk("R3 masked shift leaves register", ctl, 6'b010011);

    // R1: serial mode ignores parallel pins
    latch = 1'b1; par = 6'b111000; wait_n(6);
    chk("R1 parallel pins ignored in serial mode", ctl, 6'b010011);

    // R5: direct parallel sweep
    mode = 1'b0; wait_n(6);
    chk("R1 parallel mode takes pins", ctl, 6'b111000);
    for (int v = 0; v < 64; v++) begin
      par = 6'(v); wait_n(6);
      chk("R5 transparent parallel", ctl, 6'(v));
    end

    // R7: each single section, attenuation 2^k half-dB
    for (int k = 0; k < 6; k++) begin
      par = code_of(1 << k); wait_n(6);
      chk("R7 single section weight", ctl, 6'(63 - (1 << k)));
    end

    // R6: latched parallel
    latch = 1'b0; par = 6'b100001; wait_n(6);
    chk("R6 hold while latch low", ctl, code_of(32));
    latch = 1'b1; wait_n(6);
    latch = 1'b0; wait_n(6);
    par = 6'b011110; wait_n(6);
    chk("R6 captured value held", ctl, 6'b100001);

    // R1: in parallel mode a shifted serial word is not used
    shift_word(6'b000111, 6'b010011);
    par = 6'b110011;
    pulse_latch();
    chk("R1 serial register ignored in parallel mode", ctl, 6'b110011);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule